// File: doc/BRIEF.md
# Multidrop UART Receiver with Address Filter

This block receives asynchronous serial frames from a shared line on which several nodes listen. It runs from the system clock and samples the line once per pulse of an external tick that fires sixteen times per bit period. Each frame is either a start bit, eight data bits and a stop bit, or the same frame with a ninth data bit placed before the stop bit. The received byte, the ninth-bit (or stop-bit) value, a receive-complete flag and a sticky framing-error flag are presented as registered outputs.

On a multidrop bus, the master sends an address frame to select one node, or all nodes, and then sends data frames. With the filter enabled, the receive-complete flag is raised only for address frames that name this node or the all-nodes address 8'hFF. Once its own address has arrived, software turns the filter off so that it sees the data frames that follow. When the message is over, software turns the filter back on to wait for the next address. Software acknowledges the flags with single-cycle clear pulses.

Top module: `addr_uart_rx`

## Requirements
- R1: Data bits arrive least significant bit first, one per 16 ticks. After an accepted frame, `rx_byte` holds the eight data bits.
- R2: After an accepted frame, `rx_bit9` holds the ninth data bit when `nine_bit`=1, and holds the sampled stop-bit value when `nine_bit`=0.
- R3: `rx_done` rises at the middle of the stop bit of an accepted frame. It stays at 1 until a one-cycle pulse on `clr_done`.
- R4: A stop bit sampled as 0 sets `rx_ferr`. Later valid frames leave it set, and only a pulse on `clr_ferr` clears it. A framing error is recorded even when the frame is rejected or discarded.
- R5: With `nine_bit`=1 and `filt_en`=1, a frame is accepted only if its ninth bit is 1 and its byte equals `own_addr` or 8'hFF.
- R6: With `nine_bit`=0 and `filt_en`=1, a frame is accepted only if its stop bit is 1 and its byte equals `own_addr` or 8'hFF.
- R7: The value 8'hFF is accepted as an address match under both filter formats, whatever the value of `own_addr`.
- R8: While `rx_en` is 0, no frame is started. Dropping `rx_en` in the middle of a frame abandons that frame, and no output changes.
- R9: A frame that ends while `rx_done` is still 1 is discarded. `rx_byte`, `rx_bit9` and `rx_done` stay unchanged.
- R10: A start bit is confirmed by a majority vote of samples 7, 8 and 9 of its 16. A start that votes high is dropped, the receiver returns to idle, and no output changes.
- R11: Each data bit takes the majority of samples 7, 8 and 9, so a single-tick glitch within a bit does not change the received value.
- R12: After reset, all four outputs are 0.
- R13: A frame rejected by the filter leaves `rx_byte`, `rx_bit9` and `rx_done` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-cycle pulse, sixteen per bit period |
| rxd | input | 1 | Serial line, idle high |
| rx_en | input | 1 | Receive enable |
| nine_bit | input | 1 | 1 selects frames that carry a ninth data bit |
| filt_en | input | 1 | 1 enables address filtering |
| own_addr | input | 8 | Address of this node |
| clr_done | input | 1 | Pulse that clears `rx_done` |
| clr_ferr | input | 1 | Pulse that clears `rx_ferr` |
| rx_byte | output | 8 | Last accepted data byte |
| rx_bit9 | output | 1 | Ninth bit or stop bit of the last accepted frame |
| rx_done | output | 1 | Receive-complete flag |
| rx_ferr | output | 1 | Sticky framing-error flag |

## Verification
The bench uses the default parameters: 16 samples per bit, a 2-stage synchronizer and 8 data bits. It pulses the tick once every three clocks, so the synchronizer delay stays well under one sample. The vote window therefore lands on samples the bench can place exactly. This lets the bench drive single-tick glitches, short false starts and low stop bits to precise positions. It also makes the filter decisions for address 8'h5A and for the all-nodes address observable at the ports, in both frame formats.

// File: rtl/addr_rx_pkg.sv
package addr_rx_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_NINTH,
    RX_STOP
  } rx_state_e;

  localparam logic [7:0] BCAST_ADDR = 8'hFF;

  // two-of-three majority
  function automatic logic vote3(input logic [2:0] s);
    return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
  endfunction

  // own address or the all-nodes address
  function automatic logic addr_hit(input logic [7:0] rx, input logic [7:0] own);
    return (rx == own) || (rx == BCAST_ADDR);
  endfunction

endpackage

// File: rtl/addr_rx_sync.sv
module addr_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[STAGES-2:0], din};
  end

  assign dout = sh[STAGES-1];
endmodule

// File: rtl/addr_rx_framer.sv
module addr_rx_framer
  import addr_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rx,
  input  logic              rx_en,
  input  logic              nine_bit,
  output logic [DATA_W-1:0] data_o,
  output logic              ninth_o,
  output logic              stop_o,
  output logic              nine_o,
  output logic              frame_end
);
  localparam int CW  = $clog2(OVERSAMPLE);
  localparam int BW  = $clog2(DATA_W);
  localparam int MID = OVERSAMPLE / 2;
  localparam logic [CW-1:0] V_LO    = CW'(MID - 1);
  localparam logic [CW-1:0] V_HI    = CW'(MID + 1);
  localparam logic [CW-1:0] C_LAST  = CW'(OVERSAMPLE - 1);
  localparam logic [BW-1:0] B_LAST  = BW'(DATA_W - 1);

  rx_state_e         state;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     bidx;
  logic [2:0]        votes;
  logic              last;
  logic [DATA_W-1:0] data_q;
  logic              ninth_q;
  logic              nine_q;

  // named events
  logic [2:0] vnow;
  logic       in_win;
  logic       decide;
  logic       bit_val;

  assign vnow    = {votes[1:0], rx};
  assign in_win  = (cnt >= V_LO) && (cnt <= V_HI);
  assign decide  = tick && (state != RX_IDLE) && (cnt == V_HI);
  assign bit_val = vote3(vnow);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= RX_IDLE;
      cnt     <= '0;
      bidx    <= '0;
      votes   <= '0;
      last    <= 1'b0;
      data_q  <= '0;
      ninth_q <= 1'b0;
      nine_q  <= 1'b0;
    end else begin
      if (tick) last <= rx;
      if (!rx_en) begin
        state <= RX_IDLE;
      end else if (tick) begin
        if (state == RX_IDLE) begin
          if (last && !rx) begin
            state <= RX_START;
            cnt   <= CW'(1);
          end
        end else begin
          cnt <= (cnt == C_LAST) ? '0 : cnt + CW'(1);
          if (in_win) votes <= vnow;
          if (cnt == V_HI) begin
            case (state)
              RX_START: begin
                if (bit_val) state <= RX_IDLE;
                else begin
                  state  <= RX_DATA;
                  bidx   <= '0;
                  nine_q <= nine_bit;
                end
              end
              RX_DATA: begin
                data_q <= {bit_val, data_q[DATA_W-1:1]};
                if (bidx == B_LAST) state <= nine_q ? RX_NINTH : RX_STOP;
                else bidx <= bidx + BW'(1);
              end
              RX_NINTH: begin
                ninth_q <= bit_val;
                state   <= RX_STOP;
              end
              default: state <= RX_IDLE;
            endcase
          end
        end
      end
    end
  end

  assign frame_end = decide && (state == RX_STOP);
  assign stop_o    = bit_val;
  assign data_o    = data_q;
  assign ninth_o   = ninth_q;
  assign nine_o    = nine_q;

  // R8
  en_off_no_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !frame_end);

  // R10
  false_start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && state == RX_START && bit_val && rx_en) |=> (state == RX_IDLE));
endmodule

// File: rtl/addr_rx_accept.sv
module addr_rx_accept
  import addr_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_end,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ninth_i,
  input  logic              stop_i,
  input  logic              nine_i,
  input  logic              filt_en,
  input  logic [7:0]        own_addr,
  input  logic              clr_done,
  input  logic              clr_ferr,
  output logic [DATA_W-1:0] byte_q,
  output logic              b9_q,
  output logic              done_q,
  output logic              ferr_q,
  output logic              take
);
  logic pass;
  logic hit;

  assign hit = addr_hit(data_i[7:0], own_addr);

  always_comb begin
    pass = 1'b1;
    if (filt_en) pass = (nine_i ? ninth_i : stop_i) && hit;
  end

  assign take = frame_end && !done_q && pass;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
      b9_q   <= 1'b0;
      done_q <= 1'b0;
      ferr_q <= 1'b0;
    end else begin
      if (take) begin
        byte_q <= data_i;
        b9_q   <= nine_i ? ninth_i : stop_i;
      end
      done_q <= take | (done_q & ~clr_done);
      ferr_q <= (frame_end & ~stop_i) | (ferr_q & ~clr_ferr);
    end
  end

  // R3
  done_from_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(frame_end));

  // R9
  held_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !clr_done) |=> ($stable(byte_q) && $stable(b9_q)));

  // R4
  ferr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ferr_q && !clr_ferr) |=> ferr_q);
endmodule

// File: rtl/addr_uart_rx.sv
module addr_uart_rx
  import addr_rx_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rxd,
  input  logic       rx_en,
  input  logic       nine_bit,
  input  logic       filt_en,
  input  logic [7:0] own_addr,
  input  logic       clr_done,
  input  logic       clr_ferr,
  output logic [7:0] rx_byte,
  output logic       rx_bit9,
  output logic       rx_done,
  output logic       rx_ferr
);
  logic              rx_s;
  logic [DATA_W-1:0] f_data;
  logic              f_ninth;
  logic              f_stop;
  logic              f_nine;
  logic              f_end;
  logic              f_take;
  logic [DATA_W-1:0] byte_w;

  addr_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rx_s)
  );

  addr_rx_framer #(.OVERSAMPLE(OVERSAMPLE), .DATA_W(DATA_W)) u_framer (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .rx(rx_s), .rx_en(rx_en),
    .nine_bit(nine_bit), .data_o(f_data), .ninth_o(f_ninth), .stop_o(f_stop),
    .nine_o(f_nine), .frame_end(f_end)
  );

  addr_rx_accept #(.DATA_W(DATA_W)) u_accept (
    .clk(clk), .rst_n(rst_n), .frame_end(f_end), .data_i(f_data),
    .ninth_i(f_ninth), .stop_i(f_stop), .nine_i(f_nine), .filt_en(filt_en),
    .own_addr(own_addr), .clr_done(clr_done), .clr_ferr(clr_ferr),
    .byte_q(byte_w), .b9_q(rx_bit9), .done_q(rx_done), .ferr_q(rx_ferr),
    .take(f_take)
  );

  assign rx_byte = byte_w[7:0];

  // R5
  nine_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rx_done) && $past(filt_en) && $past(f_nine))
      |-> (rx_bit9 && addr_hit(rx_byte, $past(own_addr))));

  // R6
  eight_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rx_done) && $past(filt_en) && !$past(f_nine))
      |-> (rx_bit9 && !$past(f_stop, 1) == 1'b0 && addr_hit(rx_byte, $past(own_addr))));
endmodule

// File: tb/sim_addr_uart_rx.sv
`timescale 1ns/100ps
module sim_addr_uart_rx;
  localparam int TDIV = 3;
  localparam logic [7:0] OWN = 8'h5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick16 = 1'b0;
  logic rxd = 1'b1;
  logic rx_en = 1'b1;
  logic nine_bit = 1'b0;
  logic filt_en = 1'b0;
  logic [7:0] own_addr = OWN;
  logic clr_done = 1'b0;
  logic clr_ferr = 1'b0;
  logic [7:0] rx_byte;
  logic rx_bit9, rx_done, rx_ferr;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int tdiv_cnt = 0;
  bit busy = 1'b1;

  // reference state
  logic [7:0] m_byte = 8'h00;
  logic       m_b9 = 1'b0;
  logic       m_done = 1'b0;
  logic       m_ferr = 1'b0;

  addr_uart_rx u0 (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd), .rx_en(rx_en),
    .nine_bit(nine_bit), .filt_en(filt_en), .own_addr(own_addr),
    .clr_done(clr_done), .clr_ferr(clr_ferr), .rx_byte(rx_byte),
    .rx_bit9(rx_bit9), .rx_done(rx_done), .rx_ferr(rx_ferr)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (tdiv_cnt == TDIV - 1) begin tdiv_cnt <= 0; tick16 <= 1'b1; end
    else begin tdiv_cnt <= tdiv_cnt + 1; tick16 <= 1'b0; end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the reference while no frame is in flight
  always @(posedge clk) begin
    #1;
    if (!busy && rst_n) begin
      chk("R1 byte", rx_byte, m_byte);
      chk("R2 bit9", rx_bit9, m_b9);
      chk("R3 done", rx_done, m_done);
      chk("R4 ferr", rx_ferr, m_ferr);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!tick16) @(negedge clk);
    end
  endtask

  task automatic drive_bit(input logic v, input int glitch);
    rxd = v;
    if (glitch >= 0) begin
      ticks(glitch); rxd = ~v; ticks(1); rxd = v; ticks(15 - glitch);
    end else ticks(16);
  endtask

  // expected outcome, worked out from the requirements
  task automatic model(input logic [7:0] b, input logic n9, input logic s,
                       input logic m9, input logic flt);
    logic ok;
    if (!s) m_ferr = 1'b1;
    ok = !m_done;
    if (flt) begin
      if (m9) ok = ok && n9 && (b == own_addr || b == 8'hFF);
      else    ok = ok && s  && (b == own_addr || b == 8'hFF);
    end
    if (ok) begin
      m_byte = b;
      m_b9   = m9 ? n9 : s;
      m_done = 1'b1;
    end
  endtask

  task automatic frame(input logic [7:0] b, input logic n9, input logic s,
                       input logic m9, input logic flt,
                       input int glitch_bit, input int drop_bit);
    busy = 1'b1;
    nine_bit = m9; filt_en = flt;
    ticks(2);
    drive_bit(1'b0, -1);
    for (int i = 0; i < 8; i++) begin
      if (i == drop_bit) rx_en = 1'b0;
      drive_bit(b[i], (i == glitch_bit) ? 8 : -1);
    end
    if (m9) drive_bit(n9, -1);
    drive_bit(s, -1);
    rxd = 1'b1;
    ticks(4);
    if (drop_bit < 0 && rx_en) model(b, n9, s, m9, flt);
    rx_en = 1'b1;
    busy = 1'b0;
    @(negedge clk);
  endtask

  task automatic clear(input logic d, input logic f);
    busy = 1'b1;
    @(negedge clk); clr_done = d; clr_ferr = f;
    @(negedge clk); clr_done = 1'b0; clr_ferr = 1'b0;
    if (d) m_done = 1'b0;
    if (f) m_ferr = 1'b0;
    busy = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 byte", rx_byte, 0); chk("R12 done", rx_done, 0);
    chk("R12 ferr", rx_ferr, 0); chk("R12 bit9", rx_bit9, 0);
    busy = 1'b0;

    // R1 R2 R3: 8-bit frame
    frame(8'hA5, 1'b0, 1'b1, 1'b0, 1'b0, -1, -1);
    chk("R1 8-bit byte", rx_byte, 8'hA5); chk("R2 stop in bit9", rx_bit9, 1);
    chk("R3 done set", rx_done, 1);
    clear(1, 0);
    chk("R3 done cleared", rx_done, 0);

    // R2: 9-bit frames
    frame(8'h3C, 1'b0, 1'b1, 1'b1, 1'b0, -1, -1);
    chk("R2 ninth 0", rx_bit9, 0); chk("R1 9-bit byte", rx_byte, 8'h3C);
    clear(1, 0);
    frame(8'hC3, 1'b1, 1'b1, 1'b1, 1'b0, -1, -1);
    chk("R2 ninth 1", rx_bit9, 1);

    // R9: done still set -> discard
    frame(8'h11, 1'b0, 1'b1, 1'b0, 1'b0, -1, -1);
    chk("R9 byte kept", rx_byte, 8'hC3); chk("R9 bit9 kept", rx_bit9, 1);
    clear(1, 0);

    // R4: framing error, sticky
    frame(8'h77, 1'b0, 1'b0, 1'b0, 1'b0, -1, -1);
    chk("R4 ferr set", rx_ferr, 1); chk("R2 bad stop bit9", rx_bit9, 0);
    clear(1, 0);
    frame(8'h22, 1'b0, 1'b1, 1'b0, 1'b0, -1, -1);
    chk("R4 ferr sticky", rx_ferr, 1);
    clear(1, 1);
    chk("R4 ferr cleared", rx_ferr, 0);

    // R5 R13 R7: 9-bit filter
    frame(OWN, 1'b0, 1'b1, 1'b1, 1'b1, -1, -1);
    chk("R5 ninth 0 rejected", rx_done, 0); chk("R13 byte kept", rx_byte, 8'h22);
    frame(8'h12, 1'b1, 1'b1, 1'b1, 1'b1, -1, -1);
    chk("R5 wrong addr rejected", rx_done, 0);
    frame(OWN, 1'b1, 1'b1, 1'b1, 1'b1, -1, -1);
    chk("R5 own addr accepted", rx_done, 1); chk("R5 byte", rx_byte, OWN);
    clear(1, 0);
    frame(8'hFF, 1'b1, 1'b1, 1'b1, 1'b1, -1, -1);
    chk("R7 broadcast 9-bit", rx_done, 1);
    clear(1, 0);
    // data bytes after address with filter off
    frame(8'h04, 1'b0, 1'b1, 1'b1, 1'b0, -1, -1);
    chk("R5 data after addr", rx_byte, 8'h04);
    clear(1, 0);

    // R6 R7: 8-bit filter
    frame(OWN, 1'b0, 1'b0, 1'b0, 1'b1, -1, -1);
    chk("R6 bad stop rejected", rx_done, 0); chk("R4 ferr on reject", rx_ferr, 1);
    frame(8'h33, 1'b0, 1'b1, 1'b0, 1'b1, -1, -1);
    chk("R6 wrong addr rejected", rx_done, 0); chk("R13 byte kept 8", rx_byte, 8'h04);
    frame(8'hFF, 1'b0, 1'b1, 1'b0, 1'b1, -1, -1);
    chk("R7 broadcast 8-bit", rx_done, 1);
    clear(1, 1);
    frame(OWN, 1'b0, 1'b1, 1'b0, 1'b1, -1, -1);
    chk("R6 own addr accepted", rx_done, 1);
    clear(1, 0);

    // R8: disabled receiver
    rx_en = 1'b0;
    frame(8'h99, 1'b0, 1'b1, 1'b0, 1'b0, -1, 0);
    chk("R8 idle disabled", rx_done, 0);
    frame(8'h66, 1'b0, 1'b1, 1'b0, 1'b0, -1, 4);
    chk("R8 mid-frame drop", rx_done, 0); chk("R8 byte kept", rx_byte, OWN);

    // R10: false start
    busy = 1'b1;
    ticks(2); rxd = 1'b0; ticks(4); rxd = 1'b1; ticks(40);
    busy = 1'b0;
    @(negedge clk);
    chk("R10 false start", rx_done, 0);
    frame(8'h81, 1'b0, 1'b1, 1'b0, 1'b0, -1, -1);
    chk("R10 recovers", rx_byte, 8'h81);
    clear(1, 0);

    // R11: glitch in a bit
    frame(8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 3, -1);
    chk("R11 glitch ignored", rx_byte, 8'h00);
    clear(1, 0);
    frame(8'hFE, 1'b0, 1'b1, 1'b0, 1'b0, 5, -1);
    chk("R11 glitch high bit", rx_byte, 8'hFE);
    clear(1, 0);

    repeat (10) @(negedge clk);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule